// File: doc/BRIEF.md
# Striped Mailbox Message Sequencer

This block moves framed messages of up to eight 32-bit words between a local frame buffer and a bank of four single-word mailbox registers. Word 0 of every frame is a header, and its bits [15:8] give the frame length in words. A transmit pulse loads a whole frame. The sequencer then spreads the frame across the mailbox registers in rotation: word i goes to register i mod 4. The first four words are written back to back. A later word waits until its register reports empty. A receive pulse works the other way. It takes the header from register 0, validates the length, and collects the remaining words from the rotating registers as each one reports full. The assembled frame appears on a parallel output.

Each wait on a mailbox flag is bounded by a cycle count. If the count runs out, the frame is abandoned, and the index of the word that could not move is reported. Two interrupt-enable outputs go to the mailbox. The transmit enable is raised once a frame has been fully sent, so that the far side's drain can be signalled. The receive enable is dropped while a frame is being collected, so the arrival interrupt cannot fire again in the middle of a frame.

The controller is one state machine with six states. IDLE waits for a start pulse. HEAD reads the header on receive. CHECK validates the length. XFER moves one word per cycle, or waits on a flag. FINISH and FAIL each last one cycle. Transitions: IDLE to CHECK on a transmit start; IDLE to HEAD on a receive start; HEAD to CHECK; CHECK to FAIL on an oversize length; CHECK to FINISH on a header-only receive; CHECK to XFER otherwise; XFER to FINISH when the last word moves; XFER to FAIL when a flag wait expires; FINISH and FAIL both return to IDLE.

Top module: `msg_stream_seq`

## Requirements
- R1: After reset the block is idle: busy, done, err, the two strobes and the transmit interrupt enable are 0, err_word is 0, and the receive interrupt enable is 1.
- R2: The length is header bits [15:8]. A length of 0 or 1 moves only the header word. A length n from 2 to 8 moves exactly n words.
- R3: A length above 8 ends the frame with err=1 and err_word=0. On transmit no word is written. On receive only the header is read.
- R4: On transmit, the first min(4, n) words are written to registers 0, 1, 2, 3 in that order, in consecutive cycles. The first write comes two cycles after the cycle in which tx_start is sampled. The empty flags are not consulted for these words.
- R5: On transmit, word i (i of 4 or more) is written to register i mod 4, only in a cycle where mb_tx_empty of that register is 1.
- R6: On receive, word 0 is read from register 0 in the cycle after rx_start, with no flag check. Word i (i of 1 or more) is read from register i mod 4, only in a cycle where mb_rx_full of that register is 1. Word i of the result is rx_frame[32i+31:32i], and the words not received are 0.
- R7: rx_irq_en drops to 0 in the cycle after an accepted rx_start and stays 0 while the frame is collected. It is 1 again in the done cycle, on success and on error alike.
- R8: tx_irq_en drops to 0 when a transmit is accepted. It is 1 in the done cycle of a transmit that completes without error, and it stays 0 when the transmit fails.
- R9: A word whose flag becomes 1 within TIMEOUT consecutive cycles of waiting is moved. Otherwise the frame ends with err=1 and err_word equal to that word's index, and no further word moves.
- R10: done is a one-cycle pulse at the end of every frame. err and err_word keep their value until the next accepted start, which clears them.
- R11: A start is accepted only in IDLE. When tx_start and rx_start arrive together, the transmit wins. A start pulse during a frame has no effect, and writes and reads never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_start | input | 1 | Start pulse: send tx_frame |
| rx_start | input | 1 | Start pulse: collect a frame from the mailbox |
| tx_frame | input | 256 | Frame to send; word i at bits [32i+31:32i] |
| mb_wr_en | output | 1 | Mailbox register write strobe |
| mb_wr_sel | output | 2 | Mailbox register written |
| mb_wr_data | output | 32 | Word written |
| mb_tx_empty | input | 4 | Per-register transmit-empty flags |
| mb_rd_en | output | 1 | Mailbox register read strobe |
| mb_rd_sel | output | 2 | Mailbox register read |
| mb_rd_data | input | 32 | Word returned for mb_rd_sel in the same cycle |
| mb_rx_full | input | 4 | Per-register receive-full flags |
| tx_irq_en | output | 1 | Transmit interrupt enable for channel 0 |
| rx_irq_en | output | 1 | Receive interrupt enable for channel 0 |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | Last frame ended in error |
| err_word | output | 3 | Index of the word that failed |
| rx_frame | output | 256 | Frame buffer; holds the received frame after a receive |

## Verification
Transmit is tried with short frames while all empty flags are low. This separates the unchecked first four writes from the gated later ones. A full eight-word frame with every flag high shows the rotation wrapping back to register 0. A six-word frame with flags raised one at a time shows that the sequencer stalls on exactly the register it needs. Lengths 0, 1 and 9 probe the header decode at both ends. A flag raised in the last permitted wait cycle, and another raised one cycle too late, pin the timeout boundary. Receive is tried with flags held low after the header, with a partial set of full flags, with an oversize header and with a header-only frame. Together these show the gating, the failing index, the zero fill of the result and the restoring of the interrupt enable.

// File: rtl/msg_stream_pkg.sv
package msg_stream_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_CHECK,
        ST_XFER,
        ST_FINISH,
        ST_FAIL
    } seq_state_e;

    typedef enum logic {
        DIR_TX,
        DIR_RX
    } seq_dir_e;

endpackage

// File: rtl/msg_word_buf.sv
module msg_word_buf #(
    parameter int WORD_W    = 32,
    parameter int MAX_WORDS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_all,
    input  logic [WORD_W*MAX_WORDS-1:0]   load_frame,
    input  logic                          clear_all,
    input  logic                          wr_en,
    input  logic [$clog2(MAX_WORDS)-1:0]  wr_idx,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic [$clog2(MAX_WORDS)-1:0]  rd_idx,
    output logic [WORD_W-1:0]             rd_word,
    output logic [WORD_W*MAX_WORDS-1:0]   frame
);
    localparam int IDX_W = $clog2(MAX_WORDS);

    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_word
        logic [WORD_W-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (load_all) begin
                q <= load_frame[g*WORD_W +: WORD_W];
            end else if (clear_all) begin
                q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                q <= wr_data;
            end
        end

        assign frame[g*WORD_W +: WORD_W] = q;
    end

    assign rd_word = frame[rd_idx*WORD_W +: WORD_W];

endmodule

// File: rtl/msg_wait_timer.sv
module msg_wait_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

    // High in the last cycle of waiting that is still allowed
    assign expired = (cnt_q == TW'(LIMIT - 1));

endmodule

// File: rtl/msg_stream_seq.sv
module msg_stream_seq
    import msg_stream_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int MAX_WORDS = 8,
    parameter int NUM_REGS  = 4,
    parameter int TIMEOUT   = 100,
    parameter int LEN_LSB   = 8,
    parameter int LEN_W     = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                tx_start,
    input  logic                                rx_start,
    input  logic [WORD_W*MAX_WORDS-1:0]         tx_frame,
    output logic                                mb_wr_en,
    output logic [$clog2(NUM_REGS)-1:0]         mb_wr_sel,
    output logic [WORD_W-1:0]                   mb_wr_data,
    input  logic [NUM_REGS-1:0]                 mb_tx_empty,
    output logic                                mb_rd_en,
    output logic [$clog2(NUM_REGS)-1:0]         mb_rd_sel,
    input  logic [WORD_W-1:0]                   mb_rd_data,
    input  logic [NUM_REGS-1:0]                 mb_rx_full,
    output logic                                tx_irq_en,
    output logic                                rx_irq_en,
    output logic                                busy,
    output logic                                done,
    output logic                                err,
    output logic [$clog2(MAX_WORDS)-1:0]        err_word,
    output logic [WORD_W*MAX_WORDS-1:0]         rx_frame
);
    localparam int SEL_W = $clog2(NUM_REGS);
    localparam int IDX_W = $clog2(MAX_WORDS);
    localparam int CNT_W = $clog2(MAX_WORDS + 1);

    seq_state_e          state_q, state_d;
    seq_dir_e            dir_q;
    logic [IDX_W-1:0]    idx_q;
    logic [CNT_W-1:0]    words_q;
    logic                tx_ie_q, rx_ie_q;
    logic                err_q;
    logic [IDX_W-1:0]    err_word_q;

    logic [WORD_W*MAX_WORDS-1:0] buf_frame;
    logic [WORD_W-1:0]           buf_rd_word;
    logic                        buf_load, buf_clear, buf_wr_en;
    logic [IDX_W-1:0]            buf_wr_idx;

    logic [LEN_W-1:0]  hdr_len;
    logic              len_ok;
    logic [CNT_W-1:0]  words_hdr;
    logic [SEL_W-1:0]  lane;
    logic              direct, flag, step, stall, last, tmo_hit;
    logic              accept_tx, accept_rx;

    // R2: length decode from the header held in word 0
    assign hdr_len   = buf_frame[LEN_LSB +: LEN_W];
    assign len_ok    = (hdr_len <= LEN_W'(MAX_WORDS));
    assign words_hdr = (hdr_len <= LEN_W'(1)) ? CNT_W'(1) : hdr_len[CNT_W-1:0];

    // R4/R5/R6: rotating register choice and flag gating
    assign lane   = idx_q[SEL_W-1:0];
    assign direct = (dir_q == DIR_TX) && (CNT_W'(idx_q) < CNT_W'(NUM_REGS));
    assign flag   = (dir_q == DIR_TX) ? mb_tx_empty[lane] : mb_rx_full[lane];
    assign step   = (state_q == ST_XFER) && (direct || flag);
    assign stall  = (state_q == ST_XFER) && !direct && !flag;
    assign last   = ((CNT_W'(idx_q) + CNT_W'(1)) == words_q);

    // R11: starts only in IDLE, transmit first
    assign accept_tx = (state_q == ST_IDLE) && tx_start;
    assign accept_rx = (state_q == ST_IDLE) && !tx_start && rx_start;

    // Frame buffer shared by both directions
    assign buf_load   = accept_tx;
    assign buf_clear  = accept_rx;
    assign buf_wr_en  = (state_q == ST_HEAD) || (step && (dir_q == DIR_RX));
    assign buf_wr_idx = (state_q == ST_HEAD) ? '0 : idx_q;

    msg_word_buf #(
        .WORD_W    (WORD_W),
        .MAX_WORDS (MAX_WORDS)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_all   (buf_load),
        .load_frame (tx_frame),
        .clear_all  (buf_clear),
        .wr_en      (buf_wr_en),
        .wr_idx     (buf_wr_idx),
        .wr_data    (mb_rd_data),
        .rd_idx     (idx_q),
        .rd_word    (buf_rd_word),
        .frame      (buf_frame)
    );

    // R9: consecutive stall cycles of the current word
    msg_wait_timer #(
        .LIMIT (TIMEOUT)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (!stall),
        .tick    (stall),
        .expired (tmo_hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_start)      state_d = ST_CHECK;
                else if (rx_start) state_d = ST_HEAD;
            end
            ST_HEAD:  state_d = ST_CHECK;
            ST_CHECK: begin
                if (!len_ok)                                       state_d = ST_FAIL;
                else if (dir_q == DIR_RX && words_hdr == CNT_W'(1)) state_d = ST_FINISH;
                else                                               state_d = ST_XFER;
            end
            ST_XFER: begin
                if (step) begin
                    if (last) state_d = ST_FINISH;
                end else if (stall && tmo_hit) begin
                    state_d = ST_FAIL;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            ST_FAIL:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Datapath and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q      <= DIR_TX;
            idx_q      <= '0;
            words_q    <= CNT_W'(1);
            tx_ie_q    <= 1'b0;
            rx_ie_q    <= 1'b1;
            err_q      <= 1'b0;
            err_word_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept_tx) begin
                        dir_q      <= DIR_TX;
                        tx_ie_q    <= 1'b0;   // R8
                        err_q      <= 1'b0;   // R10
                        err_word_q <= '0;
                    end else if (accept_rx) begin
                        dir_q      <= DIR_RX;
                        rx_ie_q    <= 1'b0;   // R7
                        err_q      <= 1'b0;   // R10
                        err_word_q <= '0;
                    end
                end
                ST_CHECK: begin
                    words_q <= words_hdr;
                    idx_q   <= (dir_q == DIR_RX) ? IDX_W'(1) : '0;
                    if (!len_ok) begin
                        err_q      <= 1'b1;   // R3
                        err_word_q <= '0;
                        if (dir_q == DIR_RX) rx_ie_q <= 1'b1;
                    end else if (dir_q == DIR_RX && words_hdr == CNT_W'(1)) begin
                        rx_ie_q <= 1'b1;
                    end
                end
                ST_XFER: begin
                    if (step) begin
                        idx_q <= idx_q + IDX_W'(1);
                        if (last) begin
                            if (dir_q == DIR_TX) tx_ie_q <= 1'b1;
                            else                 rx_ie_q <= 1'b1;
                        end
                    end else if (stall && tmo_hit) begin
                        err_q      <= 1'b1;   // R9
                        err_word_q <= idx_q;
                        if (dir_q == DIR_RX) rx_ie_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mb_wr_en   = step && (dir_q == DIR_TX);
        mb_wr_sel  = lane;
        mb_wr_data = buf_rd_word;
        mb_rd_en   = (state_q == ST_HEAD) || (step && (dir_q == DIR_RX));
        mb_rd_sel  = (state_q == ST_HEAD) ? '0 : lane;
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_FINISH) || (state_q == ST_FAIL);
        tx_irq_en  = tx_ie_q;
        rx_irq_en  = rx_ie_q;
        err        = err_q;
        err_word   = err_word_q;
        rx_frame   = buf_frame;
    end

endmodule

// File: rtl/msg_stream_seq_chk.sv
module msg_stream_seq_chk #(
    parameter int NUM_REGS  = 4,
    parameter int MAX_WORDS = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          tx_start,
    input logic                          rx_start,
    input logic                          mb_wr_en,
    input logic [$clog2(NUM_REGS)-1:0]   mb_wr_sel,
    input logic [NUM_REGS-1:0]           mb_tx_empty,
    input logic                          mb_rd_en,
    input logic [$clog2(NUM_REGS)-1:0]   mb_rd_sel,
    input logic [NUM_REGS-1:0]           mb_rx_full,
    input logic                          rx_irq_en,
    input logic                          busy,
    input logic                          done,
    input logic                          err,
    input logic [$clog2(MAX_WORDS)-1:0]  err_word
);
    localparam int SEL_W = $clog2(NUM_REGS);
    localparam int CW    = $clog2(MAX_WORDS + 1) + 1;

    logic [CW-1:0] wr_cnt, rd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt <= '0;
            rd_cnt <= '0;
        end else if (!busy && (tx_start || rx_start)) begin
            wr_cnt <= '0;
            rd_cnt <= '0;
        end else begin
            if (mb_wr_en) wr_cnt <= wr_cnt + CW'(1);
            if (mb_rd_en) rd_cnt <= rd_cnt + CW'(1);
        end
    end

    // R5
    wr_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mb_wr_en |-> (mb_wr_sel == wr_cnt[SEL_W-1:0]));

    // R5
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_wr_en && (wr_cnt >= CW'(NUM_REGS))) |-> mb_tx_empty[mb_wr_sel]);

    // R6
    rd_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mb_rd_en |-> (mb_rd_sel == rd_cnt[SEL_W-1:0]));

    // R6
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_rd_en && (rd_cnt != '0)) |-> mb_rx_full[mb_rd_sel]);

    // R7
    rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mb_rd_en |-> !rx_irq_en);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !tx_start && !rx_start) |=> ($stable(err) && $stable(err_word)));

    // R11
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mb_wr_en && mb_rd_en));

endmodule

bind msg_stream_seq msg_stream_seq_chk #(
    .NUM_REGS  (NUM_REGS),
    .MAX_WORDS (MAX_WORDS)
) chk_i (.*);

// File: tb/msg_stream_seq_tb_top.sv
`timescale 1ns/1ps
module msg_stream_seq_tb_top;
    localparam int TMO = 100;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_start = 1'b0, rx_start = 1'b0;
    logic [255:0] tx_frame = '0;
    logic         mb_wr_en, mb_rd_en;
    logic [1:0]   mb_wr_sel, mb_rd_sel;
    logic [31:0]  mb_wr_data, mb_rd_data;
    logic [3:0]   mb_tx_empty = '0, mb_rx_full = '0;
    logic         tx_irq_en, rx_irq_en, busy, done, err;
    logic [2:0]   err_word;
    logic [255:0] rx_frame;

    always #2 clk = ~clk;

    msg_stream_seq #(.TIMEOUT(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .rx_start(rx_start),
        .tx_frame(tx_frame), .mb_wr_en(mb_wr_en), .mb_wr_sel(mb_wr_sel),
        .mb_wr_data(mb_wr_data), .mb_tx_empty(mb_tx_empty), .mb_rd_en(mb_rd_en),
        .mb_rd_sel(mb_rd_sel), .mb_rd_data(mb_rd_data), .mb_rx_full(mb_rx_full),
        .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en), .busy(busy), .done(done),
        .err(err), .err_word(err_word), .rx_frame(rx_frame)
    );

    int checks = 0, errors = 0;
    int cyc = 0, start_cyc = 0;
    int wr_seen = 0, rd_seen = 0, done_cnt = 0;
    int wr_cyc[$];
    logic [33:0] exp_wr[$];
    logic [1:0]  exp_rd[$];
    logic        d_err, d_tie, d_rie;
    logic [2:0]  d_ew;

    // Mailbox receive model: each register presents successive words of its lane
    logic [31:0] rx_src [8];
    logic [31:0] lane_reg [4];
    int          lane_next [4];
    assign mb_rd_data = lane_reg[mb_rd_sel];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mb_rd_en) begin
            lane_next[mb_rd_sel] <= lane_next[mb_rd_sel] + 4;
            lane_reg[mb_rd_sel]  <= (lane_next[mb_rd_sel] + 4 < 8) ?
                                    rx_src[lane_next[mb_rd_sel] + 4] : 32'h0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && mb_wr_en) begin
            wr_seen++;
            wr_cyc.push_back(cyc);
            if (exp_wr.size() == 0) chk(0, "R3", "unexpected write", {mb_wr_sel, mb_wr_data}, 0);
            else begin
                logic [33:0] e;
                e = exp_wr.pop_front();
                chk({mb_wr_sel, mb_wr_data} == e, "R5", "write lane/data", {mb_wr_sel, mb_wr_data}, e);
            end
        end
        if (rst_n && mb_rd_en) begin
            rd_seen++;
            if (exp_rd.size() == 0) chk(0, "R3", "unexpected read", mb_rd_sel, 0);
            else begin
                logic [1:0] e;
                e = exp_rd.pop_front();
                chk(mb_rd_sel == e, "R6", "read lane", mb_rd_sel, e);
            end
        end
        if (rst_n && done) begin
            done_cnt++;
            d_err = err; d_ew = err_word; d_tie = tx_irq_en; d_rie = rx_irq_en;
        end
    end

    function automatic logic [255:0] mk(input int len, input logic [31:0] seed);
        logic [255:0] f;
        f[31:0] = {seed[15:0], 8'(len), 8'h5A};
        for (int i = 1; i < 8; i++) f[i*32 +: 32] = seed ^ (32'h11111111 * i);
        return f;
    endfunction

    task automatic start_tx(input logic [255:0] f, input int nexp);
        for (int i = 0; i < nexp; i++) exp_wr.push_back({2'(i % 4), f[i*32 +: 32]});
        wr_cyc.delete();
        wr_seen = 0;
        @(negedge clk); tx_frame = f; tx_start = 1'b1; start_cyc = cyc;
        @(negedge clk); tx_start = 1'b0;
    endtask

    task automatic rx_load(input int len, input logic [31:0] seed);
        logic [255:0] f;
        f = mk(len, seed);
        @(negedge clk);
        for (int i = 0; i < 8; i++) rx_src[i] = f[i*32 +: 32];
        for (int k = 0; k < 4; k++) begin
            lane_reg[k]  <= f[k*32 +: 32];
            lane_next[k] <= k;
        end
    endtask

    task automatic start_rx(input int nexp);
        for (int i = 0; i < nexp; i++) exp_rd.push_back(2'(i % 4));
        rd_seen = 0;
        @(negedge clk); rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int snap = done_cnt;
        int n = 0;
        while (done_cnt == snap && n < 2000) begin @(posedge clk); n++; end
        chk(done_cnt != snap, req, "done seen", done_cnt, snap + 1);
        @(negedge clk);
    endtask

    task automatic tx_end(input string req, input bit e, input int ew, input bit tie);
        wait_done(req);
        chk(d_err == e, req, "err", d_err, e);
        chk(d_ew == 3'(ew), req, "err_word", d_ew, ew);
        chk(d_tie == tie, "R8", "tx_irq_en at done", d_tie, tie);
        chk(exp_wr.size() == 0, req, "writes missing", exp_wr.size(), 0);
    endtask

    task automatic rx_end(input string req, input bit e, input int ew, input int nw);
        wait_done(req);
        chk(d_err == e, req, "err", d_err, e);
        chk(d_ew == 3'(ew), req, "err_word", d_ew, ew);
        chk(d_rie == 1'b1, "R7", "rx_irq_en at done", d_rie, 1);
        chk(exp_rd.size() == 0, req, "reads missing", exp_rd.size(), 0);
        if (!e) for (int i = 0; i < 8; i++)
            chk(rx_frame[i*32 +: 32] == ((i < nw) ? rx_src[i] : 32'h0), "R6", "frame word",
                rx_frame[i*32 +: 32], (i < nw) ? rx_src[i] : 32'h0);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin lane_reg[k] = '0; lane_next[k] = 0; end
        for (int i = 0; i < 8; i++) rx_src[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({busy, done, err, mb_wr_en, mb_rd_en, tx_irq_en} == 6'b0, "R1", "idle outputs",
            {busy, done, err, mb_wr_en, mb_rd_en, tx_irq_en}, 0);
        chk(rx_irq_en == 1'b1 && err_word == 3'd0, "R1", "rx_irq_en/err_word", {rx_irq_en, err_word}, 4'b1000);

        // R4: three words, empty flags all low, back to back
        mb_tx_empty = 4'b0000;
        start_tx(mk(3, 32'hC0DE0001), 3);
        tx_end("R4", 0, 0, 1);
        chk(wr_cyc.size() == 3 && wr_cyc[0] == start_cyc + 2, "R4", "first write cycle",
            wr_cyc[0], start_cyc + 2);
        chk(wr_cyc.size() == 3 && wr_cyc[2] == wr_cyc[0] + 2, "R4", "consecutive writes",
            wr_cyc[2], wr_cyc[0] + 2);

        // R2/R5: eight words, all flags high, rotation wraps
        mb_tx_empty = 4'b1111;
        start_tx(mk(8, 32'h12340002), 8);
        tx_end("R2", 0, 0, 1);
        chk(wr_cyc.size() == 8 && wr_cyc[7] == wr_cyc[0] + 7, "R5", "full speed with flags", wr_cyc[7], wr_cyc[0] + 7);

        // R5 + R11: stall on lane 0, start pulses ignored while busy
        mb_tx_empty = 4'b0000;
        start_tx(mk(6, 32'hBEEF0003), 6);
        while (wr_seen < 4) @(posedge clk);
        rd_seen = 0;
        @(negedge clk); rx_start = 1'b1; tx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0; tx_start = 1'b0;
        repeat (8) @(negedge clk);
        chk(wr_seen == 4, "R5", "no write without empty flag", wr_seen, 4);
        mb_tx_empty = 4'b0001;
        repeat (6) @(negedge clk);
        chk(wr_seen == 5, "R5", "word 4 after lane 0 flag", wr_seen, 5);
        mb_tx_empty = 4'b0011;
        tx_end("R5", 0, 0, 1);
        repeat (3) @(negedge clk);
        chk(rd_seen == 0 && wr_seen == 6, "R11", "start during busy ignored", {rd_seen, wr_seen}, {32'd0, 32'd6});

        // R2: length 0 and 1 send header only
        start_tx(mk(0, 32'h00000004), 1);
        tx_end("R2", 0, 0, 1);
        start_tx(mk(1, 32'h00000005), 1);
        tx_end("R2", 0, 0, 1);

        // R3: oversize length
        start_tx(mk(9, 32'h00000006), 0);
        tx_end("R3", 1, 0, 0);
        chk(wr_seen == 0, "R3", "no writes on oversize", wr_seen, 0);
        // R10 hold
        repeat (20) @(negedge clk);
        chk(err == 1'b1 && done == 1'b0, "R10", "err held while idle", {err, done}, 2'b10);

        // R9 on-time: flag in last allowed wait cycle
        mb_tx_empty = 4'b0000;
        start_tx(mk(5, 32'hA0A00007), 5);
        chk(err == 1'b0, "R10", "err cleared by new start", err, 0);
        while (wr_seen < 4) @(posedge clk);
        repeat (TMO - 1) @(posedge clk);
        @(negedge clk); mb_tx_empty = 4'b0001;
        tx_end("R9", 0, 0, 1);
        mb_tx_empty = 4'b0000;

        // R9 late by one cycle
        start_tx(mk(5, 32'hA0A00008), 4);
        while (wr_seen < 4) @(posedge clk);
        repeat (TMO) @(posedge clk);
        @(negedge clk); mb_tx_empty = 4'b0001;
        tx_end("R9", 1, 4, 0);
        mb_tx_empty = 4'b0000;
        repeat (3) @(negedge clk);
        chk(wr_seen == 4, "R9", "nothing after timeout", wr_seen, 4);

        // R6/R7: receive six words, flags low at first
        mb_rx_full = 4'b0000;
        rx_load(6, 32'h55AA0009);
        start_rx(6);
        while (rd_seen < 1) @(posedge clk);
        repeat (6) @(negedge clk);
        chk(rd_seen == 1, "R6", "reads wait for full flag", rd_seen, 1);
        chk(rx_irq_en == 1'b0, "R7", "rx_irq_en low while collecting", rx_irq_en, 0);
        mb_rx_full = 4'b1111;
        rx_end("R6", 0, 0, 6);

        // R3 receive oversize
        rx_load(12, 32'h0000000A);
        start_rx(1);
        rx_end("R3", 1, 0, 1);

        // R9 receive timeout on lane 2
        mb_rx_full = 4'b0011;
        rx_load(4, 32'h0000000B);
        start_rx(2);
        rx_end("R9", 1, 2, 4);

        // R2 receive header only
        mb_rx_full = 4'b0000;
        rx_load(1, 32'h0000000C);
        start_rx(1);
        rx_end("R2", 0, 0, 1);

        // R11: simultaneous starts, transmit wins
        mb_tx_empty = 4'b1111;
        exp_wr.push_back({2'd0, mk(2, 32'h0000000D)[31:0]});
        exp_wr.push_back({2'd1, mk(2, 32'h0000000D)[63:32]});
        wr_seen = 0; rd_seen = 0;
        @(negedge clk); tx_frame = mk(2, 32'h0000000D); tx_start = 1'b1; rx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0; rx_start = 1'b0;
        tx_end("R11", 0, 0, 1);
        chk(rd_seen == 0 && wr_seen == 2, "R11", "transmit priority", {rd_seen, wr_seen}, {32'd0, 32'd2});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule